// File: doc/BRIEF.md
# Flag-Updating Integer Add Execute Unit

This execute unit performs the register-to-register add of a 64-bit fixed-point pipeline. Each cycle it can accept one 32-bit instruction word together with the two operand values already read from the register file. If the word decodes as the add instruction, the unit returns the destination index, the 64-bit sum and a write strobe one clock later.

Two instruction bits select extra work. The overflow-enable bit records signed overflow in an overflow flag and a sticky summary flag. The record bit writes a signed compare-to-zero of the result into a 4-bit condition field, with the summary flag copied into that field as well. Overflow never causes a trap. The summary flag stays set until a dedicated clear input lowers it.

Top module: `fxadd_exec`

## Requirements
- R1: Bit numbering counts bit 0 as the MSB, so instr[31-i] holds bit i. An instruction is an add only when instr[31:26] equals 31 and instr[9:1] equals 266 (all-zero register fields give 0x7C000214). The remaining fields are destination instr[25:21], overflow-enable instr[10] and record instr[0].
- R2: One cycle after an accepted add, `wr_en` is 1, `wr_idx` is the destination field and `wr_data` is (in_a + in_b) mod 2^64 with the carry-out dropped. `out_valid` is 1 one cycle after any cycle in which `in_valid` is 1. `in_ready` is always 1.
- R3: For an accepted add with overflow-enable set, `ov` becomes 1 when the two operands have the same sign and the sum has the other sign, and 0 otherwise.
- R4: An accepted add with overflow-enable clear leaves `ov` and `so` unchanged.
- R5: `so` goes to 1 whenever R3 detects overflow. Later instructions never lower it, and only `so_clr` clears it. If a clear and an overflow arrive in the same cycle, the overflow wins.
- R6: For an accepted add with the record bit set, `cr` becomes {LT, GT, EQ, S}. LT, GT and EQ are the signed 64-bit comparison of the sum with zero, and S is the value of `so` after this instruction's own update.
- R7: An accepted add with the record bit clear leaves `cr` unchanged.
- R8: When no add is accepted, `wr_en` is 0 one cycle later and `ov` and `cr` are unchanged. `so` changes only through `so_clr`.
- R9: With `rst_n` low at a clock edge, `ov`, `so`, `cr`, `wr_en` and `out_valid` are all 0 after that edge.
- R10: The sum depends only on the operand values presented with the instruction. It is unchanged when the destination index equals one or both source indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Always 1: one instruction per cycle |
| in_instr | input | 32 | Instruction word |
| in_a | input | 64 | Value of source register A |
| in_b | input | 64 | Value of source register B |
| so_clr | input | 1 | Clears the summary overflow flag |
| out_valid | output | 1 | An instruction was accepted in the previous cycle |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Sum to write back |
| ov | output | 1 | Overflow flag |
| so | output | 1 | Sticky summary overflow flag |
| cr | output | 4 | Condition field {LT, GT, EQ, S} |

## Verification
The assertions assume that `in_instr`, `in_a`, `in_b` and `so_clr` are driven to known values on every clock edge after reset, and that reset is held for at least one edge. The bench satisfies this by driving every input away from the clock edge from reset onward. Most of the random words are legal adds, with random register fields and flag bits. A share have a corrupted primary or extended opcode, and some cycles have `in_valid` low. Operand values mix random words with sign-boundary values, so that overflow, zero results and the clear/overflow collision all occur.

// File: rtl/fxadd_pkg.sv
// Package: shared field layout and decoded-instruction type for the add unit.
// Assumes the 32-bit instruction word uses MSB-first field numbering.
package fxadd_pkg;
    localparam int ILEN    = 32;
    localparam int IDX_W   = 5;
    localparam int CR_W    = 4;

    // Decoded view of one instruction word
    typedef struct packed {
        logic             hit;   // word is the add instruction
        logic [IDX_W-1:0] rt;    // destination index
        logic             oe;    // overflow recording requested
        logic             rc;    // condition record requested
    } fxadd_dec_t;
endpackage

// File: rtl/fxadd_decode.sv
// Module: recognises the add instruction and extracts the destination and flag bits.
// Assumes the primary opcode sits in the top 6 bits and the extended opcode in bits [9:1].
module fxadd_decode
    import fxadd_pkg::*;
#(
    parameter int PRIMARY_OP = 31,
    parameter int EXT_OP     = 266
) (
    input  logic [ILEN-1:0] instr,
    output fxadd_dec_t      dec
);
    localparam int PO_W = 6;
    localparam int XO_W = 9;
    localparam logic [PO_W-1:0] PO_VAL = PO_W'(PRIMARY_OP);
    localparam logic [XO_W-1:0] XO_VAL = XO_W'(EXT_OP);

    // Purpose: field compare and extraction
    always_comb begin
        dec.hit = (instr[ILEN-1 -: PO_W] == PO_VAL) && (instr[XO_W:1] == XO_VAL);
        dec.rt  = instr[ILEN-PO_W-1 -: IDX_W];
        dec.oe  = instr[XO_W+1];
        dec.rc  = instr[0];
    end
endmodule

// File: rtl/fxadd_sum.sv
// Module: modular adder with signed-overflow detection and compare-to-zero flags.
// Assumes two's-complement operands; carry-out is intentionally dropped.
module fxadd_sum #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sum,
    output logic            ovf,
    output logic            lt,
    output logic            gt,
    output logic            eq
);
    localparam int MSB = XLEN - 1;

    // Purpose: sum, overflow predicate and sign/zero flags
    always_comb begin
        sum = a + b;
        ovf = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
        lt  = sum[MSB];
        eq  = (sum == '0);
        gt  = ~lt & ~eq;
    end
endmodule

// File: rtl/fxadd_status.sv
// Module: holds the overflow flag, sticky summary flag and condition field.
// Assumes upd is a single-cycle qualifier meaning an add was accepted.
module fxadd_status
    import fxadd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic            oe,
    input  logic            rc,
    input  logic            ovf,
    input  logic            lt,
    input  logic            gt,
    input  logic            eq,
    input  logic            clr,
    output logic            ov,
    output logic            so,
    output logic [CR_W-1:0] cr
);
    logic            ov_nx;
    logic            so_nx;
    logic [CR_W-1:0] cr_nx;

    // Purpose: next state; set of summary wins over clear, record sees new summary
    always_comb begin
        so_nx = (so & ~clr) | (upd & oe & ovf);
        ov_nx = (upd & oe) ? ovf : ov;
        cr_nx = (upd & rc) ? {lt, gt, eq, so_nx} : cr;
    end

    // Purpose: status registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov <= 1'b0;
            so <= 1'b0;
            cr <= '0;
        end else begin
            ov <= ov_nx;
            so <= so_nx;
            cr <= cr_nx;
        end
    end
endmodule

// File: rtl/fxadd_exec.sv
// Module: top of the add execute unit; registers the writeback and drives the status block.
// Assumes operand values are read from the register file before this stage.
module fxadd_exec
    import fxadd_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int PRIMARY_OP = 31,
    parameter int EXT_OP     = 266
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:0]     in_instr,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic            so_clr,
    output logic            out_valid,
    output logic            wr_en,
    output logic [4:0]      wr_idx,
    output logic [XLEN-1:0] wr_data,
    output logic            ov,
    output logic            so,
    output logic [3:0]      cr
);
    fxadd_dec_t      dec;
    logic [XLEN-1:0] sum;
    logic            ovf, lt, gt, eq;
    logic            take;

    assign in_ready = 1'b1;
    assign take     = in_valid & dec.hit;

    fxadd_decode #(.PRIMARY_OP(PRIMARY_OP), .EXT_OP(EXT_OP)) u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    fxadd_sum #(.XLEN(XLEN)) u_sum (
        .a   (in_a),
        .b   (in_b),
        .sum (sum),
        .ovf (ovf),
        .lt  (lt),
        .gt  (gt),
        .eq  (eq)
    );

    fxadd_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (take),
        .oe    (dec.oe),
        .rc    (dec.rc),
        .ovf   (ovf),
        .lt    (lt),
        .gt    (gt),
        .eq    (eq),
        .clr   (so_clr),
        .ov    (ov),
        .so    (so),
        .cr    (cr)
    );

    // Purpose: writeback strobes with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= take;
        end
    end

    // Purpose: writeback index and data, loaded on an accepted add
    always_ff @(posedge clk) begin
        if (take) begin
            wr_idx  <= dec.rt;
            wr_data <= sum;
        end
    end
endmodule

// File: rtl/fxadd_exec_chk.sv
// Module: property checker for fxadd_exec, attached with bind.
// Assumes inputs carry known values at every edge after reset.
module fxadd_exec_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     in_instr,
    input logic [XLEN-1:0] in_a,
    input logic [XLEN-1:0] in_b,
    input logic            so_clr,
    input logic            wr_en,
    input logic [XLEN-1:0] wr_data,
    input logic            ov,
    input logic            so,
    input logic [3:0]      cr
);
    logic            is_add;
    logic [XLEN-1:0] s;
    logic            no_ovf;

    assign is_add = in_valid && in_instr[31:26] == 6'd31 && in_instr[9:1] == 9'd266;
    assign s      = in_a + in_b;
    assign no_ovf = (in_a[XLEN-1] != in_b[XLEN-1]) || (s[XLEN-1] == in_a[XLEN-1]);

    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (!ov && !so && cr == 4'd0 && !wr_en));

    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_add |=> (wr_en && wr_data == $past(in_a + in_b)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && in_instr[10] && no_ovf) |=> !ov);

    p_ov_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && !in_instr[10]) |=> $stable(ov));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (so && !so_clr) |=> so);

    p_cr_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && in_instr[0]) |=> cr[0] == so);

    p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_add |=> (!wr_en && $stable(cr) && $stable(ov)));
endmodule

bind fxadd_exec fxadd_exec_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_instr (in_instr),
    .in_a     (in_a),
    .in_b     (in_b),
    .so_clr   (so_clr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ov       (ov),
    .so       (so),
    .cr       (cr)
);

// File: tb/tb_fxadd_exec.sv
// Bench: directed corners plus seeded random stimulus against a bench-side model.
module tb_fxadd_exec;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_instr;
    logic [63:0] in_a, in_b;
    logic        so_clr;
    logic        out_valid, wr_en, ov, so;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic [3:0]  cr;

    int total = 0;
    int bad   = 0;

    logic       m_ov, m_so;
    logic [3:0] m_cr;

    always #4 clk = ~clk;

    fxadd_exec dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_a(in_a), .in_b(in_b), .so_clr(so_clr),
        .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ov(ov), .so(so), .cr(cr)
    );

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic oe, input logic rc);
        return {6'd31, rt, ra, rb, oe, 9'd266, rc};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one instruction: drive at negedge, check after the next posedge
    task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] a,
                        input logic [63:0] b, input logic clr);
        logic        hit, acc, oe, rc, ovf;
        logic [63:0] s;
        @(negedge clk);
        in_valid = v; in_instr = ins; in_a = a; in_b = b; so_clr = clr;
        hit = (ins[31:26] == 6'd31) && (ins[9:1] == 9'd266);
        acc = v && hit;
        oe  = ins[10];
        rc  = ins[0];
        s   = a + b;
        ovf = (a[63] == b[63]) && (s[63] != a[63]);
        m_so = (m_so && !clr) || (acc && oe && ovf);
        if (acc && oe) m_ov = ovf;
        if (acc && rc) m_cr = {$signed(s) < 0, $signed(s) > 0, s == 64'd0, m_so};
        @(posedge clk);
        #1;
        chk("R2 in_ready", {63'd0, in_ready}, 64'd1);
        chk("R2 out_valid", {63'd0, out_valid}, {63'd0, v});
        chk(hit ? "R2 wr_en" : "R8 R1 wr_en", {63'd0, wr_en}, {63'd0, acc});
        if (acc) begin
            chk("R2 wr_idx", {59'd0, wr_idx}, {59'd0, ins[25:21]});
            chk("R2 wr_data", wr_data, s);
        end
        chk((acc && oe) ? "R3 ov" : "R4 R8 ov", {63'd0, ov}, {63'd0, m_ov});
        chk("R5 so", {63'd0, so}, {63'd0, m_so});
        chk((acc && rc) ? "R6 cr" : "R7 R8 cr", {60'd0, cr}, {60'd0, m_cr});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; so_clr = 1'b0;
        @(posedge clk);
        #1;
        m_ov = 1'b0; m_so = 1'b0; m_cr = 4'd0;
        chk("R9 ov", {63'd0, ov}, 64'd0);
        chk("R9 so", {63'd0, so}, 64'd0);
        chk("R9 cr", {60'd0, cr}, 64'd0);
        chk("R9 wr_en", {63'd0, wr_en}, 64'd0);
        chk("R9 out_valid", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb;
        logic [31:0] w;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; in_a = '0; in_b = '0; so_clr = 1'b0;
        m_ov = 1'b0; m_so = 1'b0; m_cr = 4'd0;
        do_reset();
        chk("R1 base word", {32'd0, mk(5'd0, 5'd0, 5'd0, 1'b0, 1'b0)}, 64'h7C000214);
        // R3 R6: largest positive plus one overflows, record shows LT and S
        step(1, mk(5'd4, 5'd1, 5'd2, 1, 1), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0);
        chk("R6 cr value", {60'd0, cr}, 64'h9);
        // R4: no overflow enable keeps ov
        step(1, mk(5'd4, 5'd1, 5'd2, 0, 0), 64'd5, 64'd6, 0);
        // R3 R5: overflow enable without overflow clears ov, so stays
        step(1, mk(5'd4, 5'd1, 5'd2, 1, 0), 64'd5, 64'd6, 0);
        // R5: clear alone
        step(0, 32'd0, 64'd0, 64'd0, 1);
        // R6: negative+negative wraps to zero, EQ and S
        step(1, mk(5'd7, 5'd1, 5'd2, 1, 1), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0);
        chk("R6 cr zero", {60'd0, cr}, 64'h3);
        // R5: clear and overflow together, overflow wins
        step(1, mk(5'd7, 5'd1, 5'd2, 1, 1), 64'h7000_0000_0000_0000, 64'h7000_0000_0000_0000, 1);
        chk("R5 collide", {63'd0, so}, 64'd1);
        // R1 R8: wrong extended and wrong primary opcode
        step(1, mk(5'd3, 5'd1, 5'd2, 1, 1) ^ 32'h0000_0002, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0);
        step(1, mk(5'd3, 5'd1, 5'd2, 1, 1) ^ 32'h0400_0000, 64'd0, 64'd0, 0);
        // R10: destination aliases both sources
        step(1, mk(5'd3, 5'd3, 5'd3, 0, 1), 64'd21, 64'd21, 0);
        chk("R10 alias data", wr_data, 64'd42);
        step(1, mk(5'd9, 5'd9, 5'd2, 0, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0);
        // R9: reset after state was set
        step(1, mk(5'd1, 5'd1, 5'd2, 1, 1), 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            w = mk(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 7) == 0) w = w ^ (32'd1 << $urandom_range(1, 31));
            if ($urandom_range(0, 7) == 0) w[20:11] = $urandom;
            case ($urandom_range(0, 3))
                0: begin ra = 64'h7FFF_FFFF_FFFF_FFFF - 64'($urandom_range(0, 3)); rb = 64'($urandom_range(0, 3)); end
                1: begin ra = 64'h8000_0000_0000_0000 + 64'($urandom_range(0, 3)); rb = ~64'($urandom_range(0, 3)); end
                2: begin ra = 64'($urandom_range(0, 5)); rb = -64'($urandom_range(0, 5)); end
                default: begin ra = {$urandom, $urandom}; rb = {$urandom, $urandom}; end
            endcase
            step($urandom_range(0, 5) != 0, w, ra, rb, $urandom_range(0, 15) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule